// File: doc/BRIEF.md
# Filtered Event Detector with Timestamp Capture

This block watches one active-low external event line from a low-power time-keeping circuit. The line is resynchronised to the block clock and then debounced over a chosen number of 32.768 kHz ticks. It is looked at only on sampling instants, which can be every tick or one of three slow periods. When detection is enabled and a stable low level is present at a sampling instant, the block raises a sticky event flag. It also copies the current time-of-day vector into a timestamp register, but only if the flag was clear.

An armed halt option lets a detected event raise a request that freezes the time-of-day counter kept outside this block. The request stays up until software writes the time registers. That same write also disarms the option. A gated copy of the event flag goes to an output pin. In battery mode a disable bit can force that pin inactive, which saves power.

Top module: `evt_stamp_det`

## Requirements
- R1: After reset, `evt_flag`, `evt_stamp`, `halt_req`, `halt_arm` and `evt_out` are all 0.
- R2: With `cfg_rate`=00 (sample on every tick), `cfg_filt`=00 (no filter) and `cfg_det_en`=1, a low level on `evt_pin_n` sets `evt_flag` within 5 clock cycles.
- R3: With `cfg_filt`=01, the low level must stay stable for 128 ticks before it counts as an event. Codes 10 and 11 need 512 and 1024 ticks. A low pulse shorter than the window leaves `evt_flag` at 0.
- R4: Any change of the synchronised input restarts the filter count from zero, so a one-cycle high glitch inside a low period delays the event by a full window.
- R5: With `cfg_rate`=01, 10 or 11, the input is judged only every 16384, 32768 or 131072 ticks. With a steady low input, two successive qualifications are exactly one period apart.
- R6: While `cfg_det_en`=0, no event is detected. `evt_flag` does not set, `evt_stamp` does not change, and `halt_req` does not set.
- R7: Only the first event after the flag is cleared loads `evt_stamp` from `time_in`. Later events leave it unchanged until `flag_clr`.
- R8: `flag_clr` wins over an event that qualifies in the same cycle, and the flag reads 0 after that edge. The stamp is taken from `time_in` in the cycle in which the event qualifies.
- R9: When `halt_arm`=1 and an event is detected, `halt_req` rises to 1 and stays there while further events come and go.
- R10: A pulse on `time_wr` clears `halt_req` and `halt_arm` at the same edge. It takes priority over a halt-arm write and over an event in that cycle.
- R11: `halt_arm`=1 has no effect while `cfg_det_en`=0, and `halt_req` stays 0.
- R12: `evt_out` equals `evt_flag`, except that it is forced to 0 whenever both `batt_mode`=1 and `cfg_bat_dis`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| evt_pin_n | input | 1 | Raw event line, active low, asynchronous |
| cfg_rate | input | 2 | Sampling rate: 00 every tick, 01 16384, 10 32768, 11 131072 ticks |
| cfg_filt | input | 2 | Filter window: 00 none, 01 128, 10 512, 11 1024 ticks |
| cfg_det_en | input | 1 | Detection and timestamp enable |
| cfg_halt_wr | input | 1 | Write strobe for the halt-arm bit |
| cfg_halt_din | input | 1 | Value written to the halt-arm bit |
| cfg_bat_dis | input | 1 | Disable the event output in battery mode |
| batt_mode | input | 1 | Running from the backup supply |
| time_in | input | TIME_W | Current time-of-day vector |
| time_wr | input | 1 | Strobe: time registers written |
| flag_clr | input | 1 | Strobe: clear the event flag |
| evt_flag | output | 1 | Sticky event flag |
| evt_stamp | output | TIME_W | Time captured at the first event |
| halt_req | output | 1 | Request to freeze the time counter |
| halt_arm | output | 1 | Current halt-on-event setting |
| evt_out | output | 1 | Event output after battery-mode masking |

## Verification
Two pairs of functions can land on one clock edge. The first pair is a flag clear and a fresh qualification. With a continuous low input, sampling every tick and no filter, every edge qualifies. A `flag_clr` pulse therefore always meets an event. The bench checks that the flag reads 0 after that edge and that the stamp keeps its old value. It then checks that the flag is set again one edge later, with the `time_in` value presented in that later cycle. The second pair is a time write and an armed event. The bench pulses `time_wr` while events keep qualifying and expects both `halt_req` and `halt_arm` to be 0 afterwards.

// File: rtl/evt_pkg.sv
package evt_pkg;

  typedef enum logic [1:0] {
    RATE_EVERY = 2'b00,
    RATE_SLOW1 = 2'b01,
    RATE_SLOW2 = 2'b10,
    RATE_SLOW3 = 2'b11
  } rate_sel_e;

  typedef enum logic [1:0] {
    FILT_NONE  = 2'b00,
    FILT_SHORT = 2'b01,
    FILT_MID   = 2'b10,
    FILT_LONG  = 2'b11
  } filt_sel_e;

  // Pick one of three limits by a two-bit code; code 0 returns zero.
  function automatic int unsigned pick_limit(input logic [1:0] sel,
                                             input int unsigned l1,
                                             input int unsigned l2,
                                             input int unsigned l3);
    case (sel)
      2'b01:   return l1;
      2'b10:   return l2;
      2'b11:   return l3;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/evt_sampler.sv
module evt_sampler
  import evt_pkg::*;
#(
  parameter int unsigned PER1 = 16384,
  parameter int unsigned PER2 = 32768,
  parameter int unsigned PER3 = 131072
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [1:0] rate,
  output logic       smp_stb
);
  localparam int unsigned CW = $clog2(PER3 + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_val;
  logic          at_end;

  always_comb begin
    last_val = CW'(pick_limit(rate, PER1, PER2, PER3) - 1);
    at_end   = (rate == RATE_EVERY) || (cnt_q >= last_val);
    smp_stb  = tick_en && at_end;
    cnt_d    = cnt_q;
    if (tick_en) begin
      if (at_end) cnt_d = '0;
      else        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/evt_filter.sv
module evt_filter
  import evt_pkg::*;
#(
  parameter int unsigned WIN1 = 128,
  parameter int unsigned WIN2 = 512,
  parameter int unsigned WIN3 = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       pin_n,
  input  logic [1:0] filt,
  output logic       lvl_low,
  output logic       stable
);
  localparam int unsigned FW = $clog2(WIN3 + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_q;
  logic [FW-1:0]          cnt_q, cnt_d;
  logic [FW-1:0]          win;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= pin_n;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      end
    end
  endgenerate

  always_comb begin
    win   = FW'(pick_limit(filt, WIN1, WIN2, WIN3));
    cnt_d = cnt_q;
    if (synced != lvl_q)              cnt_d = '0;
    else if (tick_en && cnt_q < win)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      lvl_q <= synced;
      cnt_q <= cnt_d;
    end
  end

  assign lvl_low = !lvl_q;
  assign stable  = (filt == FILT_NONE) || ((cnt_q >= win) && (synced == lvl_q));

endmodule

// File: rtl/evt_capture.sv
module evt_capture #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qual,
  input  logic              flag_clr,
  input  logic [TIME_W-1:0] time_in,
  input  logic              time_wr,
  input  logic              halt_wr,
  input  logic              halt_din,
  output logic              flag,
  output logic [TIME_W-1:0] stamp,
  output logic              halt_req,
  output logic              halt_arm
);
  logic              flag_d, halt_req_d, halt_arm_d, stamp_ld;
  logic [TIME_W-1:0] stamp_q;
  logic              flag_q, halt_req_q, halt_arm_q;

  always_comb begin
    stamp_ld = 1'b0;
    flag_d   = flag_q;
    if (flag_clr) begin
      flag_d = 1'b0;
    end else if (qual && !flag_q) begin
      flag_d   = 1'b1;
      stamp_ld = 1'b1;
    end

    halt_arm_d = halt_arm_q;
    if (time_wr)      halt_arm_d = 1'b0;
    else if (halt_wr) halt_arm_d = halt_din;

    halt_req_d = halt_req_q;
    if (time_wr)                 halt_req_d = 1'b0;
    else if (qual && halt_arm_q) halt_req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q     <= 1'b0;
      halt_req_q <= 1'b0;
      halt_arm_q <= 1'b0;
    end else begin
      flag_q     <= flag_d;
      halt_req_q <= halt_req_d;
      halt_arm_q <= halt_arm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stamp_q <= '0;
    else if (stamp_ld) stamp_q <= time_in;
  end

  assign flag     = flag_q;
  assign stamp    = stamp_q;
  assign halt_req = halt_req_q;
  assign halt_arm = halt_arm_q;

endmodule

// File: rtl/evt_stamp_det.sv
module evt_stamp_det #(
  parameter int unsigned TIME_W = 32,
  parameter int unsigned WIN1   = 128,
  parameter int unsigned WIN2   = 512,
  parameter int unsigned WIN3   = 1024,
  parameter int unsigned PER1   = 16384,
  parameter int unsigned PER2   = 32768,
  parameter int unsigned PER3   = 131072
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              evt_pin_n,
  input  logic [1:0]        cfg_rate,
  input  logic [1:0]        cfg_filt,
  input  logic              cfg_det_en,
  input  logic              cfg_halt_wr,
  input  logic              cfg_halt_din,
  input  logic              cfg_bat_dis,
  input  logic              batt_mode,
  input  logic [TIME_W-1:0] time_in,
  input  logic              time_wr,
  input  logic              flag_clr,
  output logic              evt_flag,
  output logic [TIME_W-1:0] evt_stamp,
  output logic              halt_req,
  output logic              halt_arm,
  output logic              evt_out
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       smp_stb, lvl_low, stable, qual;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  evt_sampler #(.PER1(PER1), .PER2(PER2), .PER3(PER3)) i_sampler (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_en (tick_en),
    .rate    (cfg_rate),
    .smp_stb (smp_stb)
  );

  evt_filter #(.WIN1(WIN1), .WIN2(WIN2), .WIN3(WIN3), .SYNC_STAGES(2)) i_filter (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_en (tick_en),
    .pin_n   (evt_pin_n),
    .filt    (cfg_filt),
    .lvl_low (lvl_low),
    .stable  (stable)
  );

  assign qual = smp_stb && cfg_det_en && lvl_low && stable;

  evt_capture #(.TIME_W(TIME_W)) i_capture (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .qual     (qual),
    .flag_clr (flag_clr),
    .time_in  (time_in),
    .time_wr  (time_wr),
    .halt_wr  (cfg_halt_wr),
    .halt_din (cfg_halt_din),
    .flag     (evt_flag),
    .stamp    (evt_stamp),
    .halt_req (halt_req),
    .halt_arm (halt_arm)
  );

  assign evt_out = evt_flag && !(batt_mode && cfg_bat_dis);

endmodule

// File: rtl/evt_stamp_det_chk.sv
module evt_stamp_det_chk #(
  parameter int unsigned TIME_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_det_en,
  input logic              cfg_bat_dis,
  input logic              batt_mode,
  input logic              time_wr,
  input logic              flag_clr,
  input logic              evt_flag,
  input logic [TIME_W-1:0] evt_stamp,
  input logic              halt_req,
  input logic              halt_arm,
  input logic              evt_out
);

  AST_STAMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flag |=> $stable(evt_stamp)); // R7

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !evt_flag); // R8

  AST_TIME_WRITE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> (!halt_req && !halt_arm)); // R10

  AST_DISABLED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_det_en && !evt_flag) |=> !evt_flag); // R6

  AST_DISABLED_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_det_en && !halt_req) |=> !halt_req); // R11

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !time_wr) |=> halt_req); // R9

  AST_BATT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_mode && cfg_bat_dis) |-> !evt_out); // R12

endmodule

bind evt_stamp_det evt_stamp_det_chk #(.TIME_W(TIME_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_det_en  (cfg_det_en),
  .cfg_bat_dis (cfg_bat_dis),
  .batt_mode   (batt_mode),
  .time_wr     (time_wr),
  .flag_clr    (flag_clr),
  .evt_flag    (evt_flag),
  .evt_stamp   (evt_stamp),
  .halt_req    (halt_req),
  .halt_arm    (halt_arm),
  .evt_out     (evt_out)
);

// File: tb/test_evt_stamp_det.sv
module test_evt_stamp_det;
  localparam int TW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b1;
  logic          evt_pin_n = 1'b1;
  logic [1:0]    cfg_rate = 2'b00;
  logic [1:0]    cfg_filt = 2'b00;
  logic          cfg_det_en = 1'b0;
  logic          cfg_halt_wr = 1'b0;
  logic          cfg_halt_din = 1'b0;
  logic          cfg_bat_dis = 1'b0;
  logic          batt_mode = 1'b0;
  logic [TW-1:0] time_in = '0;
  logic          time_wr = 1'b0;
  logic          flag_clr = 1'b0;
  logic          evt_flag, halt_req, halt_arm, evt_out;
  logic [TW-1:0] evt_stamp;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evt_stamp_det i_evt_stamp_det (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .evt_pin_n(evt_pin_n),
    .cfg_rate(cfg_rate), .cfg_filt(cfg_filt), .cfg_det_en(cfg_det_en),
    .cfg_halt_wr(cfg_halt_wr), .cfg_halt_din(cfg_halt_din),
    .cfg_bat_dis(cfg_bat_dis), .batt_mode(batt_mode), .time_in(time_in),
    .time_wr(time_wr), .flag_clr(flag_clr), .evt_flag(evt_flag),
    .evt_stamp(evt_stamp), .halt_req(halt_req), .halt_arm(halt_arm),
    .evt_out(evt_out)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    chk("R1", "flag", evt_flag, 0);
    chk("R1", "stamp", evt_stamp, 0);
    chk("R1", "halt_req", halt_req, 0);
    chk("R1", "halt_arm", halt_arm, 0);
    chk("R1", "evt_out", evt_out, 0);
  endtask

  task automatic t_basic();
    cfg_det_en = 1'b1;
    time_in = 32'h0000_1111;
    evt_pin_n = 1'b0;
    wait_n(5);
    chk("R2", "flag after low", evt_flag, 1);
    chk("R2", "stamp", evt_stamp, 32'h1111);
    time_in = 32'h0000_2222;
    wait_n(6);
    chk("R7", "stamp kept on later events", evt_stamp, 32'h1111);
  endtask

  task automatic t_clear_race();
    // Input stays low: every edge qualifies.
    time_in  = 32'h0000_AAAA;
    flag_clr = 1'b1;
    @(negedge clk);
    chk("R8", "flag after clear edge", evt_flag, 0);
    chk("R8", "stamp after clear edge", evt_stamp, 32'h1111);
    flag_clr = 1'b0;
    time_in  = 32'h0000_BBBB;
    @(negedge clk);
    chk("R8", "flag one edge later", evt_flag, 1);
    chk("R7", "restamp after clear", evt_stamp, 32'hBBBB);
  endtask

  task automatic t_filter();
    evt_pin_n = 1'b1;
    cfg_filt  = 2'b01;
    wait_n(5);
    clear_flag();
    evt_pin_n = 1'b0;
    wait_n(100);
    evt_pin_n = 1'b1;
    wait_n(10);
    chk("R3", "short pulse rejected", evt_flag, 0);
    evt_pin_n = 1'b0;
    wait_n(120);
    chk("R3", "before window", evt_flag, 0);
    wait_n(20);
    chk("R3", "after window", evt_flag, 1);
  endtask

  task automatic t_bounce();
    evt_pin_n = 1'b1;
    wait_n(5);
    clear_flag();
    evt_pin_n = 1'b0;
    wait_n(100);
    evt_pin_n = 1'b1;
    @(negedge clk);
    evt_pin_n = 1'b0;
    wait_n(100);
    chk("R4", "glitch restarts window", evt_flag, 0);
    wait_n(40);
    chk("R4", "event after restart", evt_flag, 1);
  endtask

  task automatic t_rate();
    int n;
    evt_pin_n = 1'b1;
    cfg_filt  = 2'b00;
    cfg_rate  = 2'b01;
    wait_n(5);
    clear_flag();
    evt_pin_n = 1'b0;
    n = 0;
    while (!evt_flag && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk("R5", "first slow sample seen", evt_flag, 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    n = 1;
    while (!evt_flag && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk("R5", "sample spacing", n, 16384);
    cfg_rate = 2'b00;
  endtask

  task automatic t_disabled();
    evt_pin_n = 1'b1;
    wait_n(4);
    clear_flag();
    cfg_det_en   = 1'b0;
    cfg_halt_wr  = 1'b1;
    cfg_halt_din = 1'b1;
    time_in      = 32'h0000_CCCC;
    @(negedge clk);
    cfg_halt_wr  = 1'b0;
    chk("R11", "arm written", halt_arm, 1);
    evt_pin_n = 1'b0;
    wait_n(20);
    chk("R6", "no flag when disabled", evt_flag, 0);
    chk("R6", "stamp unchanged", evt_stamp, 32'hBBBB);
    chk("R11", "no halt when disabled", halt_req, 0);
  endtask

  task automatic t_halt();
    cfg_det_en = 1'b1;
    wait_n(5);
    chk("R9", "halt on event", halt_req, 1);
    evt_pin_n = 1'b1;
    wait_n(20);
    chk("R9", "halt held", halt_req, 1);
    evt_pin_n = 1'b0;
    wait_n(5);
    // Time write races a continuing event and an arm write.
    time_wr      = 1'b1;
    cfg_halt_wr  = 1'b1;
    cfg_halt_din = 1'b1;
    @(negedge clk);
    time_wr     = 1'b0;
    cfg_halt_wr = 1'b0;
    chk("R10", "halt released", halt_req, 0);
    chk("R10", "arm cleared", halt_arm, 0);
    wait_n(10);
    chk("R10", "no halt while disarmed", halt_req, 0);
  endtask

  task automatic t_batt();
    chk("R12", "flag set", evt_flag, 1);
    batt_mode = 1'b1; cfg_bat_dis = 1'b0;
    @(negedge clk);
    chk("R12", "batt, output enabled", evt_out, 1);
    cfg_bat_dis = 1'b1;
    @(negedge clk);
    chk("R12", "batt, output disabled", evt_out, 0);
    batt_mode = 1'b0;
    @(negedge clk);
    chk("R12", "mains, disable ignored", evt_out, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_clear_race();
    t_filter();
    t_bounce();
    t_rate();
    t_disabled();
    t_halt();
    t_batt();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule